// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Mode

This block is a timekeeping counter for a chip that needs wall-clock time and a calendar. A pulse on a 100 Hz enable input advances a set of packed-BCD fields. The fields are hundredths, seconds, minutes, hours, weekday, day of month, month and a two-digit year. A carry out of one field advances the next field, up to the year. The hours field runs either as a 24-hour count or as a 12-hour count with a PM flag.

All eight byte registers are always visible in parallel on one 64-bit output. A bus controller sets the time by presenting all eight bytes together with a load strobe. A stop bit held in the weekday byte freezes the count without losing the stored value.

Top module: `bcd_calendar_clock`

## Requirements
- R1: The eight bytes appear on `regs_out` with byte k at bits [8k+7:8k], in this order: k=0 hundredths (00-99), 1 seconds, 2 minutes, 3 hours, 4 weekday (1-7), 5 date, 6 month, 7 year. After reset the value is 2000-style year 00, month 01, date 01, weekday 1, 00:00:00.00, 24-hour mode and running (`64'h0001010100000000`).
- R2: Each cycle with `tick_100hz` high, no load and the clock running, hundredths increase by one in BCD. Hundredths carry 99->00 into seconds, seconds carry 59->00 into minutes, and minutes carry 59->00 into hours. With `tick_100hz` low the registers hold.
- R3: Hours bit 7 low selects 24-hour mode. In that mode hours bits [5:4] are the tens digit and bits [3:0] the ones digit, and 23 rolls to 00, which advances the day. Bit 7 is kept across every tick.
- R4: Hours bit 7 high selects 12-hour mode. In that mode bit 5 is the PM flag (1 = PM), bit 4 the tens digit and bits [3:0] the ones digit. Hour 11 advances to 12 and toggles PM, and hour 12 advances to 01 with PM unchanged. Only the change from PM to AM advances the day.
- R5: Weekday bit 5 is a stop bit. While it is 1, ticks leave every register unchanged. While it is 0, the clock counts.
- R6: After the last day of the month, the date goes to 01 and the month advances. Months 04, 06, 09 and 11 end on 30, February ends on 28, and all other months end on 31.
- R7: When the year value is divisible by 4 (00 included), February ends on 29.
- R8: On each day advance, the weekday (bits [2:0]) goes from 7 to 1 and otherwise increases by one. Month 12 rolls to 01 and advances the year, and year 99 rolls to 00.
- R9: `load_en` high copies `load_data` into all eight registers at the next clock edge. The load takes priority over a tick in the same cycle.
- R10: Unused bits always read 0, and a load ignores the `load_data` bits at those positions. The unused bits are: seconds and minutes bit 7, hours bit 6, weekday bits 7, 6, 4 and 3, date bits 7:6, and month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle enable, one per hundredth of a second |
| load_en | input | 1 | Load all eight registers from load_data |
| load_data | input | 64 | Eight bytes to load, byte k at [8k+7:8k] |
| regs_out | output | 64 | Current eight register bytes, byte k at [8k+7:8k] |

## Verification
The bound checker checks five things on every cycle:
- unused bits stay zero;
- a load lands exactly, masked, one cycle later;
- the stop bit and an absent tick both freeze all 64 bits;
- the 12/24 select survives anything but a load;
- a tick below 99 hundredths steps only the hundredths byte.

The multi-field rollovers need the bench scenarios with a reference model: midnight in both hour modes, the noon toggle, month ends of 30 and 31 days, February in leap and non-leap years, the year wrap and the weekday wrap.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int NUM_REGS     = 8;
    localparam int REG_W        = 8;
    localparam int BUS_W        = NUM_REGS * REG_W;
    localparam int HR_MODE_BIT  = 7;
    localparam int HR_PM_BIT    = 5;
    localparam int DOW_STOP_BIT = 5;
    localparam int DAY_W        = 5;

    typedef logic [REG_W-1:0] byte_t;

    // Field order matters: hund sits at the low byte of the packed struct.
    typedef struct packed {
        byte_t year;
        byte_t mon;
        byte_t date;
        byte_t dow;
        byte_t hour;
        byte_t min;
        byte_t sec;
        byte_t hund;
    } cal_regs_t;

    localparam cal_regs_t USED_MASK = '{
        year: 8'hFF, mon: 8'h1F, date: 8'h3F, dow: 8'h27,
        hour: 8'hBF, min: 8'h7F, sec: 8'h7F, hund: 8'hFF
    };

    localparam cal_regs_t RESET_VAL = '{
        year: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
        hour: 8'h00, min: 8'h00, sec: 8'h00, hund: 8'h00
    };

    function automatic logic [6:0] bcd2bin(input byte_t b);
        return 7'(({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]});
    endfunction

    function automatic byte_t bin2bcd(input logic [6:0] v);
        logic [6:0] t;
        logic [6:0] o;
        t = v / 7'd10;
        o = v % 7'd10;
        return {t[3:0], o[3:0]};
    endfunction
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  byte_t            mon_bcd,
    input  byte_t            year_bcd,
    output logic [DAY_W-1:0] last_day
);
    logic [6:0] mon_b;
    logic [6:0] year_b;
    logic       leap;

    always_comb begin
        mon_b  = bcd2bin(mon_bcd & USED_MASK.mon);
        year_b = bcd2bin(year_bcd);
        leap   = (year_b[1:0] == 2'b00);
        case (mon_b)
            7'd2:                       last_day = leap ? DAY_W'(29) : DAY_W'(28);
            7'd4, 7'd6, 7'd9, 7'd11:    last_day = DAY_W'(30);
            default:                    last_day = DAY_W'(31);
        endcase
    end
endmodule

// File: rtl/cal_time_step.sv
module cal_time_step
    import cal_pkg::*;
(
    input  cal_regs_t        cur,
    input  logic [DAY_W-1:0] last_day,
    output cal_regs_t        nxt
);
    logic [6:0] hu_b, se_b, mi_b, hr_b, dt_b, mo_b, yr_b, hr_n;
    logic [2:0] dw_b;
    logic       c_sec, c_min, c_hr, c_day, c_mon, c_yr;
    logic       pm_n;
    byte_t      hr_bcd;

    always_comb begin
        nxt    = cur;
        c_sec  = 1'b0; c_min = 1'b0; c_hr = 1'b0;
        c_day  = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
        pm_n   = cur.hour[HR_PM_BIT];
        hr_n   = '0;
        hr_bcd = '0;
        dw_b   = cur.dow[2:0];

        hu_b = bcd2bin(cur.hund);
        se_b = bcd2bin(cur.sec & USED_MASK.sec);
        mi_b = bcd2bin(cur.min & USED_MASK.min);
        dt_b = bcd2bin(cur.date & USED_MASK.date);
        mo_b = bcd2bin(cur.mon & USED_MASK.mon);
        yr_b = bcd2bin(cur.year);
        if (cur.hour[HR_MODE_BIT]) hr_b = bcd2bin({3'b000, cur.hour[4:0]});
        else                       hr_b = bcd2bin({2'b00, cur.hour[5:0]});

        if (hu_b >= 7'd99) begin nxt.hund = '0; c_sec = 1'b1; end
        else                     nxt.hund = bin2bcd(hu_b + 7'd1);

        if (c_sec) begin
            if (se_b >= 7'd59) begin nxt.sec = '0; c_min = 1'b1; end
            else                     nxt.sec = bin2bcd(se_b + 7'd1);
        end

        if (c_min) begin
            if (mi_b >= 7'd59) begin nxt.min = '0; c_hr = 1'b1; end
            else                     nxt.min = bin2bcd(mi_b + 7'd1);
        end

        if (c_hr) begin
            if (cur.hour[HR_MODE_BIT]) begin
                if (hr_b == 7'd11) begin
                    hr_n  = 7'd12;
                    pm_n  = ~cur.hour[HR_PM_BIT];
                    c_day = cur.hour[HR_PM_BIT];
                end else if (hr_b >= 7'd12) begin
                    hr_n = 7'd1;
                end else begin
                    hr_n = hr_b + 7'd1;
                end
                hr_bcd   = bin2bcd(hr_n);
                nxt.hour = {1'b1, 1'b0, pm_n, hr_bcd[4:0]};
            end else begin
                if (hr_b >= 7'd23) begin hr_n = '0; c_day = 1'b1; end
                else                     hr_n = hr_b + 7'd1;
                hr_bcd   = bin2bcd(hr_n);
                nxt.hour = {2'b00, hr_bcd[5:0]};
            end
        end

        if (c_day) begin
            nxt.dow = {cur.dow[7:3], (dw_b >= 3'd7) ? 3'd1 : dw_b + 3'd1};
            if (dt_b >= {2'b00, last_day}) begin nxt.date = 8'h01; c_mon = 1'b1; end
            else                                 nxt.date = bin2bcd(dt_b + 7'd1);
        end

        if (c_mon) begin
            if (mo_b >= 7'd12) begin nxt.mon = 8'h01; c_yr = 1'b1; end
            else                     nxt.mon = bin2bcd(mo_b + 7'd1);
        end

        if (c_yr) begin
            if (yr_b >= 7'd99) nxt.year = '0;
            else               nxt.year = bin2bcd(yr_b + 7'd1);
        end
    end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_100hz,
    input  logic             load_en,
    input  logic [BUS_W-1:0] load_data,
    output logic [BUS_W-1:0] regs_out
);
    cal_regs_t        state_d, state_q;
    cal_regs_t        step_nxt;
    logic [DAY_W-1:0] last_day;

    cal_month_len u_len (
        .mon_bcd  (state_q.mon),
        .year_bcd (state_q.year),
        .last_day (last_day)
    );

    cal_time_step u_step (
        .cur      (state_q),
        .last_day (last_day),
        .nxt      (step_nxt)
    );

    always_comb begin
        state_d = state_q;
        if (load_en)
            state_d = cal_regs_t'(load_data & BUS_W'(USED_MASK));
        else if (tick_100hz && !state_q.dow[DOW_STOP_BIT])
            state_d = step_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_VAL;
        else        state_q <= state_d;
    end

    assign regs_out = BUS_W'(state_q);
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
    import cal_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_100hz,
    input logic             load_en,
    input logic [BUS_W-1:0] load_data,
    input logic [BUS_W-1:0] regs_out
);
    localparam logic [BUS_W-1:0] MASK_V = BUS_W'(USED_MASK);
    localparam int STOP_POS = 4 * REG_W + DOW_STOP_BIT;
    localparam int MODE_POS = 3 * REG_W + HR_MODE_BIT;

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_out & ~MASK_V) == '0);

    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> regs_out == $past(load_data & MASK_V));

    p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && regs_out[STOP_POS]) |=> $stable(regs_out));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !tick_100hz) |=> $stable(regs_out));

    p_mode_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(regs_out[MODE_POS]));

    p_hund_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && tick_100hz && !regs_out[STOP_POS] && bcd2bin(regs_out[7:0]) < 7'd99)
        |=> ($stable(regs_out[BUS_W-1:8]) &&
             bcd2bin(regs_out[7:0]) == bcd2bin($past(regs_out[7:0])) + 7'd1));
endmodule

bind bcd_calendar_clock cal_clock_checker u_chk (.*);

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_100hz = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_data = '0;
    logic [63:0] regs_out;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [63:0] MASK = 64'hFF1F3F27BF7F7FFF;

    typedef struct {
        int hu, se, mi, hr, pm, m12, stop, dw, dt, mo, yr;
    } mdl_t;

    mdl_t ref_m;

    bcd_calendar_clock u_bcd_calendar_clock (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz),
        .load_en(load_en), .load_data(load_data), .regs_out(regs_out)
    );

    always #4 clk = ~clk;

    function automatic int mlen(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] tob(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int frb(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [63:0] enc(mdl_t m);
        logic [7:0] h;
        logic [7:0] hb;
        hb = tob(m.hr);
        if (m.m12 != 0) h = {1'b1, 1'b0, 1'(m.pm), hb[4:0]};
        else            h = {2'b00, hb[5:0]};
        return {tob(m.yr), tob(m.mo), tob(m.dt),
                {2'b00, 1'(m.stop), 2'b00, 3'(m.dw)}, h,
                tob(m.mi), tob(m.se), tob(m.hu)};
    endfunction

    function automatic mdl_t dec(logic [63:0] d);
        mdl_t m;
        m.hu   = frb(d[7:0]);
        m.se   = frb(d[15:8] & 8'h7F);
        m.mi   = frb(d[23:16] & 8'h7F);
        m.m12  = int'(d[31]);
        m.pm   = m.m12 != 0 ? int'(d[29]) : 0;
        m.hr   = m.m12 != 0 ? frb(d[31:24] & 8'h1F) : frb(d[31:24] & 8'h3F);
        m.stop = int'(d[37]);
        m.dw   = int'(d[34:32]);
        m.dt   = frb(d[47:40] & 8'h3F);
        m.mo   = frb(d[55:48] & 8'h1F);
        m.yr   = frb(d[63:56]);
        return m;
    endfunction

    function automatic mdl_t adv(mdl_t m);
        int day;
        if (m.stop != 0) return m;
        m.hu++;
        if (m.hu < 100) return m;
        m.hu = 0; m.se++;
        if (m.se < 60) return m;
        m.se = 0; m.mi++;
        if (m.mi < 60) return m;
        m.mi = 0;
        day = 0;
        if (m.m12 != 0) begin
            if (m.hr == 11) begin
                m.hr = 12;
                m.pm = (m.pm != 0) ? 0 : 1;
                day  = (m.pm == 0) ? 1 : 0;
            end else if (m.hr == 12) m.hr = 1;
            else m.hr++;
        end else begin
            m.hr++;
            if (m.hr == 24) begin m.hr = 0; day = 1; end
        end
        if (day == 0) return m;
        m.dw = (m.dw == 7) ? 1 : m.dw + 1;
        m.dt++;
        if (m.dt <= mlen(m.mo, m.yr)) return m;
        m.dt = 1; m.mo++;
        if (m.mo <= 12) return m;
        m.mo = 1;
        m.yr = (m.yr + 1) % 100;
        return m;
    endfunction

    function automatic mdl_t mk(int yr, int mo, int dt, int dw, int stop,
                                int m12, int pm, int hr, int mi, int se, int hu);
        mdl_t m;
        m.yr = yr; m.mo = mo; m.dt = dt; m.dw = dw; m.stop = stop;
        m.m12 = m12; m.pm = pm; m.hr = hr; m.mi = mi; m.se = se; m.hu = hu;
        return m;
    endfunction

    function automatic mdl_t rnd_m();
        mdl_t m;
        m.m12  = int'($urandom % 2);
        m.pm   = int'($urandom % 2);
        m.hr   = (m.m12 != 0) ? 1 + int'($urandom % 12) : int'($urandom % 24);
        if ($urandom % 3 == 0) m.hr = (m.m12 != 0) ? 11 : 23;
        m.mi   = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
        m.se   = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
        m.hu   = 90 + int'($urandom % 10);
        m.yr   = int'($urandom % 100);
        m.mo   = 1 + int'($urandom % 12);
        m.dt   = ($urandom % 2 == 0) ? mlen(m.mo, m.yr) : 1 + int'($urandom % 28);
        m.dw   = 1 + int'($urandom % 7);
        m.stop = ($urandom % 8 == 0) ? 1 : 0;
        return m;
    endfunction

    task automatic check(logic [63:0] exp, string tag);
        n_tests++;
        if (regs_out !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, regs_out, exp);
        end
    endtask

    task automatic drive(logic ld, logic [63:0] d, logic tk, string tag);
        load_en    = ld;
        load_data  = d;
        tick_100hz = tk;
        @(posedge clk);
        #2;
        if (ld)      ref_m = dec(d);
        else if (tk) ref_m = adv(ref_m);
        check(enc(ref_m), tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        check(64'h0001010100000000, "R1 reset value");
        ref_m = dec(64'h0001010100000000);

        // R9: load together with a tick, load wins
        drive(1'b1, enc(mk(23, 2, 28, 7, 0, 0, 0, 23, 59, 59, 98)), 1'b1, "R9 load over tick");
        drive(1'b0, '0, 1'b0, "R2 no tick holds");
        drive(1'b0, '0, 1'b1, "R2 hundredths step");
        drive(1'b0, '0, 1'b1, "R3 R6 R8 midnight Feb28 non-leap");
        // R7 leap year February
        drive(1'b1, enc(mk(24, 2, 28, 3, 0, 0, 0, 23, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R7 Feb28 to Feb29");
        drive(1'b1, enc(mk(24, 2, 29, 4, 0, 0, 0, 23, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R7 Feb29 to Mar1");
        drive(1'b1, enc(mk(0, 2, 28, 4, 0, 0, 0, 23, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R7 year 00 leap");
        // R6 30-day month
        drive(1'b1, enc(mk(10, 4, 30, 2, 0, 0, 0, 23, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R6 Apr30 to May1");
        drive(1'b1, enc(mk(10, 5, 30, 2, 0, 0, 0, 23, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R6 May30 to May31");
        // R8 year wrap
        drive(1'b1, enc(mk(99, 12, 31, 6, 0, 0, 0, 23, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R8 year 99 wrap");
        // R4 12-hour mode
        drive(1'b1, enc(mk(5, 1, 31, 1, 0, 1, 0, 11, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R4 11AM to 12PM");
        drive(1'b1, enc(mk(5, 1, 31, 1, 0, 1, 1, 12, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R4 12PM to 01PM");
        drive(1'b1, enc(mk(5, 1, 31, 1, 0, 1, 1, 11, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R4 11PM to 12AM next day");
        drive(1'b1, enc(mk(5, 1, 12, 1, 0, 1, 0, 12, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R4 12AM to 01AM");
        // R5 stop bit
        drive(1'b1, enc(mk(7, 3, 3, 3, 1, 0, 0, 10, 59, 59, 99)), 1'b0, "R9 load");
        for (int i = 0; i < 5; i++) drive(1'b0, '0, 1'b1, "R5 stopped holds");
        drive(1'b1, enc(mk(7, 3, 3, 3, 0, 0, 0, 10, 59, 59, 99)), 1'b0, "R9 load");
        drive(1'b0, '0, 1'b1, "R5 running counts");
        // R10 unused bits ignored on load
        drive(1'b1, enc(mk(42, 7, 15, 5, 0, 0, 0, 13, 45, 30, 12)) | ~MASK, 1'b0, "R10 unused 24h");
        drive(1'b1, enc(mk(42, 7, 15, 5, 0, 1, 1, 9, 45, 30, 12)) | ~MASK, 1'b0, "R10 unused 12h");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 3) drive(1'b1, enc(rnd_m()) | (($urandom % 2 == 0) ? ~MASK : '0), 1'b0, "R9 R10 random load");
            else       drive(1'b0, '0, ($urandom % 5 != 0), "R2 R3 R4 R6 R8 random run");
        end

        load_en    = 1'b0;
        tick_100hz = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule